// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the front of an Ethernet receive path and decides, from the six destination address bytes at the head of each frame, whether the frame is kept. The bytes arrive one per valid cycle. A start-of-frame marker comes with the first byte. One cycle after the sixth byte, the block gives a one-cycle decision pulse. The pulse carries an accept bit and a 16-bit packet-type status word that a neighbouring receive status writer ORs into its frame status.

The decision follows a fixed priority:
- Promiscuous mode admits individual (unicast) addresses only.
- Accept-all-group mode admits any group address and marks it as multicast.
- Broadcast mode admits the all-ones address and marks it as broadcast.
- Otherwise a 16-entry exact-match table is searched. Each entry has its own enable bit.

The table is written one whole entry at a time as three 16-bit words. While the receiver is held in its reset mode, software can read any entry back one word at a time.

Top module: `dest_addr_filter`

## Requirements
- R1: After reset, decValid, decAccept and decType are 0, and every table entry reads back as 0.
- R2: A byte with inValid=1 and inSof=1 starts an address. The next five valid bytes complete it; cycles with inValid=0 may fall between them. One clock after the sixth byte, decValid is 1 for exactly one cycle. Valid bytes that arrive after the sixth byte, or with no open address, are ignored. When decValid is 0, decAccept and decType are 0.
- R3: With modePromisc=1, an address whose first byte has bit 0 clear is accepted with decType=0. A first byte with bit 0 set does not match this rule and falls to the later checks.
- R4: With modeAllGroup=1, an address whose first byte has bit 0 set is accepted with decType=16'h0100 (bit 8). This rule takes priority over broadcast, so the all-ones address gives 16'h0100 when both modes are on.
- R5: With modeBcast=1 and no earlier rule taken, an address of six 8'hFF bytes is accepted with decType=16'h0080 (bit 7).
- R6: If no earlier rule is taken and the address equals any table entry whose bit in entryEnable is 1, the frame is accepted with decType=0. Several matching entries give the same single accept.
- R7: A frame that no rule accepts gives decAccept=0 and decType=0. This includes a match on a table entry whose enable bit is 0.
- R8: tblWrEn=1 writes entry tblWrIdx at the clock edge. Word j of tblWrWords is bits [16j+15:16j]. Its low byte is address byte 2j and its high byte is address byte 2j+1, where byte 0 is the first byte received.
- R9: When inResetMode=1, rdData is word rdWordSel (packed as in R8) of entry rdPtr; rdWordSel=3 gives 0. When inResetMode=0, rdData is 0.
- R10: A start-of-frame byte in the middle of an address discards the partial address and starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inByte | input | 8 | Destination address byte |
| inValid | input | 1 | inByte is valid this cycle |
| inSof | input | 1 | inByte is the first address byte |
| modePromisc | input | 1 | Accept every individual address |
| modeAllGroup | input | 1 | Accept every group address |
| modeBcast | input | 1 | Accept the broadcast address |
| entryEnable | input | 16 | Per-entry match enable, bit i for entry i |
| tblWrEn | input | 1 | Write one table entry |
| tblWrIdx | input | 4 | Entry to write |
| tblWrWords | input | 48 | Three 16-bit address words of the entry |
| inResetMode | input | 1 | Receiver held in reset mode; enables readback |
| rdPtr | input | 4 | Entry to read back |
| rdWordSel | input | 2 | Word of the entry to read back |
| rdData | output | 16 | Readback word |
| decValid | output | 1 | Decision strobe |
| decAccept | output | 1 | Frame accepted |
| decType | output | 16 | Packet-type status (bit 8 multicast, bit 7 broadcast) |

## Verification
A byte counter that drifts moves the decision pulse to the wrong cycle, or makes it vanish or repeat. A reference model that expects the strobe exactly one clock after the sixth byte catches this on the very next decision. A wrong byte lane in the table or the address register turns table matches into rejects, which shows at the first decision of a frame that should hit. The same fault also swaps bytes in the readback words at once, while the bench sweeps entries in reset mode. A wrong priority or flag position shows up in decType in the decision cycle, for frames that meet two rules at once, such as the all-ones address with both group and broadcast modes on.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_BITS  = ADDR_BYTES * 8;
  localparam int WORD_BITS  = 16;
  localparam int ADDR_WORDS = ADDR_BITS / WORD_BITS;
  localparam int IDX_W      = $clog2(ADDR_BYTES);
  localparam int WSEL_W     = $clog2(ADDR_WORDS + 1);
  // status word flag positions decoded by the receive status writer
  localparam int FLAG_GROUP = 8;
  localparam int FLAG_BCAST = 7;

  typedef struct packed {
    logic             capture;
    logic             last;
    logic [IDX_W-1:0] idx;
  } byte_strobe_t;
endpackage

// File: rtl/daf_ctrl.sv
module daf_ctrl
  import daf_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         inSof,
  output byte_strobe_t strb
);
  logic [IDX_W-1:0] byteCnt;
  logic [IDX_W-1:0] curIdx;
  logic             take;
  logic             isLast;

  always_comb begin
    curIdx = inSof ? '0 : byteCnt;
    take   = inValid && (inSof || (byteCnt != '0));
    isLast = take && (curIdx == IDX_W'(ADDR_BYTES - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     byteCnt <= '0;
    else if (take) byteCnt <= isLast ? '0 : curIdx + 1'b1;
  end

  assign strb = '{capture: take, last: isLast, idx: curIdx};

  // R2: counter stays inside one address
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    byteCnt < IDX_W'(ADDR_BYTES));

  // R10: start of frame always reopens at the second byte slot
  p_sof_restart_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSof) |=> (byteCnt == IDX_W'(1)));
endmodule

// File: rtl/daf_datapath.sv
module daf_datapath
  import daf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int SEL_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  byte_strobe_t           strb,
  input  logic [7:0]             inByte,
  input  logic                   modePromisc,
  input  logic                   modeAllGroup,
  input  logic                   modeBcast,
  input  logic [NUM_ENTRIES-1:0] entryEnable,
  input  logic                   tblWrEn,
  input  logic [SEL_W-1:0]       tblWrIdx,
  input  logic [ADDR_BITS-1:0]   tblWrWords,
  input  logic                   inResetMode,
  input  logic [SEL_W-1:0]       rdPtr,
  input  logic [WSEL_W-1:0]      rdWordSel,
  output logic [WORD_BITS-1:0]   rdData,
  output logic                   decValid,
  output logic                   decAccept,
  output logic [WORD_BITS-1:0]   decType
);
  localparam logic [WORD_BITS-1:0] FLAG_MASK =
    (WORD_BITS'(1) << FLAG_GROUP) | (WORD_BITS'(1) << FLAG_BCAST);

  logic [ADDR_BITS-1:0]   addrHold;
  logic [ADDR_BITS-1:0]   fullAddr;
  logic [ADDR_BITS-1:0]   tbl [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hitVec;
  logic                   nextAccept;
  logic [WORD_BITS-1:0]   nextType;
  logic [ADDR_BITS-1:0]   rdEntry;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             addrHold <= '0;
    else if (strb.capture) addrHold[{strb.idx, 3'b000} +: 8] <= inByte;
  end

  // the last byte joins the held bytes in the cycle it arrives
  assign fullAddr = {inByte, addrHold[ADDR_BITS-9:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENTRIES; e++) tbl[e] <= '0;
    end else if (tblWrEn) begin
      tbl[tblWrIdx] <= tblWrWords;
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_match
    assign hitVec[i] = entryEnable[i] && (tbl[i] == fullAddr);
  end

  always_comb begin
    nextAccept = 1'b0;
    nextType   = '0;
    if (modePromisc && !fullAddr[0]) begin
      nextAccept = 1'b1;
    end else if (modeAllGroup && fullAddr[0]) begin
      nextAccept           = 1'b1;
      nextType[FLAG_GROUP] = 1'b1;
    end else if (modeBcast && (&fullAddr)) begin
      nextAccept           = 1'b1;
      nextType[FLAG_BCAST] = 1'b1;
    end else if (|hitVec) begin
      nextAccept = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      decValid  <= 1'b0;
      decAccept <= 1'b0;
      decType   <= '0;
    end else begin
      decValid  <= strb.last;
      decAccept <= strb.last && nextAccept;
      decType   <= strb.last ? nextType : '0;
    end
  end

  assign rdEntry = tbl[rdPtr];

  always_comb begin
    rdData = '0;
    if (inResetMode) begin
      for (int k = 0; k < ADDR_WORDS; k++) begin
        if (rdWordSel == WSEL_W'(k)) rdData = rdEntry[k*WORD_BITS +: WORD_BITS];
      end
    end
  end

  // R2: exactly one strobe per completed address
  p_pulse_after_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.last |=> decValid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.last |=> !decValid);
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> (!decAccept && (decType == '0)));
  // R7: a type flag only comes with an accept
  p_flag_needs_accept_r7: assert property (@(posedge clk) disable iff (!rstN)
    (decType != '0) |-> decAccept);
  // R4: at most one flag, only at the two defined positions
  p_flag_shape_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(decType) && ((decType & ~FLAG_MASK) == '0));
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int SEL_W       = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [7:0]             inByte,
  input  logic                   inValid,
  input  logic                   inSof,
  input  logic                   modePromisc,
  input  logic                   modeAllGroup,
  input  logic                   modeBcast,
  input  logic [NUM_ENTRIES-1:0] entryEnable,
  input  logic                   tblWrEn,
  input  logic [SEL_W-1:0]       tblWrIdx,
  input  logic [ADDR_BITS-1:0]   tblWrWords,
  input  logic                   inResetMode,
  input  logic [SEL_W-1:0]       rdPtr,
  input  logic [WSEL_W-1:0]      rdWordSel,
  output logic [WORD_BITS-1:0]   rdData,
  output logic                   decValid,
  output logic                   decAccept,
  output logic [WORD_BITS-1:0]   decType
);
  byte_strobe_t strb;

  daf_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inSof   (inSof),
    .strb    (strb)
  );

  daf_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .SEL_W       (SEL_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .inByte       (inByte),
    .modePromisc  (modePromisc),
    .modeAllGroup (modeAllGroup),
    .modeBcast    (modeBcast),
    .entryEnable  (entryEnable),
    .tblWrEn      (tblWrEn),
    .tblWrIdx     (tblWrIdx),
    .tblWrWords   (tblWrWords),
    .inResetMode  (inResetMode),
    .rdPtr        (rdPtr),
    .rdWordSel    (rdWordSel),
    .rdData       (rdData),
    .decValid     (decValid),
    .decAccept    (decAccept),
    .decType      (decType)
  );
endmodule

// File: tb/tb_dest_addr_filter.sv
`timescale 1ns/1ps
module tb_dest_addr_filter;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic [7:0]  inByte = '0;
  logic        inValid = 1'b0, inSof = 1'b0;
  logic        modePromisc = 1'b0, modeAllGroup = 1'b0, modeBcast = 1'b0;
  logic [N-1:0] entryEnable = '0;
  logic        tblWrEn = 1'b0;
  logic [3:0]  tblWrIdx = '0;
  logic [47:0] tblWrWords = '0;
  logic        inResetMode = 1'b0;
  logic [3:0]  rdPtr = '0;
  logic [1:0]  rdWordSel = '0;
  logic [15:0] rdData;
  logic        decValid, decAccept;
  logic [15:0] decType;

  always #2 clk = ~clk;

  dest_addr_filter dut (
    .clk(clk), .rstN(rstN), .inByte(inByte), .inValid(inValid), .inSof(inSof),
    .modePromisc(modePromisc), .modeAllGroup(modeAllGroup), .modeBcast(modeBcast),
    .entryEnable(entryEnable), .tblWrEn(tblWrEn), .tblWrIdx(tblWrIdx),
    .tblWrWords(tblWrWords), .inResetMode(inResetMode), .rdPtr(rdPtr),
    .rdWordSel(rdWordSel), .rdData(rdData), .decValid(decValid),
    .decAccept(decAccept), .decType(decType)
  );

  int    checks = 0, errors = 0, cyc = 0;
  string curReq = "R1";
  bit    cmpOn = 0;

  // behavioural reference model
  logic [7:0]  q[$];
  logic [7:0]  mtbl [N][6];
  logic        expValid = 0, expAccept = 0;
  logic [15:0] expType = 0, expRd;
  bit          took, hit, allff, m;

  initial foreach (mtbl[e, k]) mtbl[e][k] = 8'h00;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q.delete();
      expValid = 0; expAccept = 0; expType = 0;
      foreach (mtbl[e, k]) mtbl[e][k] = 8'h00;
    end else begin
      took = 0;
      expValid = 0; expAccept = 0; expType = 0;
      if (inValid) begin
        if (inSof) begin q.delete(); q.push_back(inByte); took = 1; end
        else if (q.size() > 0 && q.size() < 6) begin q.push_back(inByte); took = 1; end
      end
      if (took && q.size() == 6) begin
        allff = 1;
        for (int k = 0; k < 6; k++) if (q[k] != 8'hFF) allff = 0;
        hit = 0;
        for (int e = 0; e < N; e++) begin
          if (entryEnable[e]) begin
            m = 1;
            for (int k = 0; k < 6; k++) if (mtbl[e][k] != q[k]) m = 0;
            if (m) hit = 1;
          end
        end
        expValid = 1;
        if (modePromisc && !q[0][0]) expAccept = 1;
        else if (modeAllGroup && q[0][0]) begin expAccept = 1; expType = 16'h0100; end
        else if (modeBcast && allff) begin expAccept = 1; expType = 16'h0080; end
        else if (hit) expAccept = 1;
        q.delete();
      end
      if (tblWrEn) begin
        for (int j = 0; j < 3; j++) begin
          mtbl[tblWrIdx][2*j]   = tblWrWords[16*j +: 8];
          mtbl[tblWrIdx][2*j+1] = tblWrWords[16*j+8 +: 8];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      #1;
      expRd = 16'h0000;
      if (inResetMode && rdWordSel < 2'd3)
        expRd = {mtbl[rdPtr][2*rdWordSel+1], mtbl[rdPtr][2*rdWordSel]};
      checks++;
      if (decValid !== expValid || decAccept !== expAccept ||
          decType !== expType || rdData !== expRd) begin
        errors++;
        $display("FAIL %s t=%0t: valid/accept/type/rd actual %b %b %h %h expected %b %b %h %h",
                 curReq, $time, decValid, decAccept, decType, rdData,
                 expValid, expAccept, expType, expRd);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk); inValid = 0; inSof = 0; inByte = 8'h00;
    end
  endtask

  task automatic sendByte(logic [7:0] b, logic s);
    @(negedge clk); inValid = 1; inSof = s; inByte = b;
  endtask

  task automatic sendAddr(logic [47:0] a, int tail);
    for (int k = 0; k < 6; k++) sendByte(a[47-8*k -: 8], k == 0);
    idle(tail);
  endtask

  task automatic writeEntry(int e, logic [47:0] a);
    @(negedge clk);
    tblWrEn = 1; tblWrIdx = e[3:0];
    for (int j = 0; j < 3; j++)
      tblWrWords[16*j +: 16] = {a[47-8*(2*j+1) -: 8], a[47-8*(2*j) -: 8]};
    @(negedge clk); tblWrEn = 0;
  endtask

  task automatic sweepRead(int e);
    for (int s = 0; s < 4; s++) begin
      @(negedge clk); rdPtr = e[3:0]; rdWordSel = s[1:0];
    end
  endtask

  initial begin
    #1 rstN = 0;
    @(negedge clk); cmpOn = 1;
    curReq = "R1";
    repeat (2) @(negedge clk);
    rstN = 1;
    inResetMode = 1;
    for (int e = 0; e < N; e++) sweepRead(e);

    curReq = "R8";
    writeEntry(3, 48'h021122334455);
    writeEntry(9, 48'h021122334455);
    writeEntry(12, 48'h0A0B0C0D0E0F);
    sweepRead(3); sweepRead(9); sweepRead(12); sweepRead(0);

    curReq = "R9";
    inResetMode = 0;
    sweepRead(3); sweepRead(12);
    inResetMode = 1;
    sweepRead(12);

    curReq = "R6";
    entryEnable = 16'h0008;
    sendAddr(48'h021122334455, 2);
    entryEnable = 16'h0208;
    sendAddr(48'h021122334455, 2);
    entryEnable = 16'h1000;
    sendAddr(48'h0A0B0C0D0E0F, 2);

    curReq = "R7";
    entryEnable = 16'h0200;
    sendAddr(48'h0A0B0C0D0E0F, 2);
    sendAddr(48'h021122334456, 2);
    entryEnable = 16'h0000;
    sendAddr(48'h021122334455, 2);

    curReq = "R3";
    modePromisc = 1;
    sendAddr(48'h5A0000000001, 2);
    sendAddr(48'h01005E000001, 2);
    entryEnable = 16'h0008;
    sendAddr(48'h021122334455, 2);
    entryEnable = 16'h0000;

    curReq = "R4";
    modePromisc = 0; modeAllGroup = 1;
    sendAddr(48'h01005E000001, 2);
    modeBcast = 1;
    sendAddr(48'hFFFFFFFFFFFF, 2);
    sendAddr(48'h5A0000000001, 2);

    curReq = "R5";
    modeAllGroup = 0;
    sendAddr(48'hFFFFFFFFFFFF, 2);
    sendAddr(48'hFFFFFFFFFFFE, 2);
    modeBcast = 0;
    sendAddr(48'hFFFFFFFFFFFF, 2);

    curReq = "R2";
    entryEnable = 16'h0008;
    for (int k = 0; k < 8; k++) sendByte(8'h02, 0);
    idle(2);
    sendByte(8'h02, 1); idle(1); sendByte(8'h11, 0); idle(3);
    sendByte(8'h22, 0); sendByte(8'h33, 0); idle(1);
    sendByte(8'h44, 0); sendByte(8'h55, 0); idle(2);
    sendAddr(48'h021122334455, 0);
    for (int k = 0; k < 7; k++) sendByte(8'hFF, 0);
    idle(3);

    curReq = "R10";
    sendByte(8'h0A, 1); sendByte(8'h0B, 0); sendByte(8'h0C, 0);
    sendAddr(48'h021122334455, 2);
    entryEnable = 16'h1000;
    sendByte(8'h02, 1); sendByte(8'h11, 0);
    sendAddr(48'h0A0B0C0D0E0F, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule